// File: doc/BRIEF.md
# Low-Power Wake and Interrupt Arbiter

This block puts a small CPU into one of two sleep modes and decides, for every interrupt request, two separate things: whether the request wakes the CPU, and whether the CPU then vectors to a service routine. A light sleep (HALT) gates only the CPU clock. A deep sleep (STOP) also gates the oscillator. Software enters either mode with a one-cycle write strobe. The block holds the maskable request bits in banks of pending flags, plus one pending flag for the non-maskable request. The CPU supplies the current 2-bit service level, the master enable and the per-source enable bits.

Waking and vectoring are decided independently. A request can bring the CPU back so that it resumes the instruction after the sleep write, without entering any service routine. This depends on the service level and the master enable. When the CPU does vector, the block raises a one-cycle take strobe. It reports the winning source, clears that source's pending flag and drives the updated service level back to the CPU.

Service levels: 0 = idle, 1 = servicing a maskable or software interrupt, 2 = servicing a non-maskable interrupt, 3 = reserved for debug servicing.

Top module: `lpw_wake_arb`

## Requirements
- R1: After synchronous reset, `cpu_clk_en` and `osc_en` are 1. `wake_pulse`, `take_int`, `level_out` and all pending flags are 0.
- R2: One cycle after a `halt_wr` strobe with no wake source pending, `cpu_clk_en` is 0 and `osc_en` stays 1.
- R3: One cycle after a `stop_wr` strobe with no wake source pending, both `cpu_clk_en` and `osc_en` are 0. `osc_en` is never 0 while `cpu_clk_en` is 1.
- R4: While asleep, a maskable request whose `ie` bit is 0 stays pending. It does not wake the CPU and is never taken.
- R5: A pending non-maskable request wakes the CPU whatever `mie` and `ie` are. A wake returns to run mode with both enables at 1 in the same cycle, and `wake_pulse` is high for exactly that cycle.
- R6: A non-maskable request taken at `level_in` 0 or 1 produces a take strobe with `take_nmi`=1 one cycle after the wake. `level_out` becomes 2 and `nmi_pend` clears.
- R7: At `level_in` 2 or 3, a non-maskable request wakes the CPU but is not taken. It stays pending.
- R8: An enabled maskable request with `mie`=0 wakes the CPU without a take strobe.
- R9: An enabled maskable request is taken only when `mie`=1 and `level_in`=0. The take sets `level_out` to 1 and clears the served bit. With `mie`=1 and `level_in`≥1 the request wakes the CPU without being taken.
- R10: A non-maskable request is taken before any maskable one. Among maskable requests the lowest index wins, where index = bank×8 + bit with 4 banks of 8 bits. Simultaneous requests are taken one per cycle in that order.
- R11: A sleep strobe issued while a wake source is already pending does not gate any clock. `wake_pulse` rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_wr | input | 1 | Strobe: enter HALT (CPU clock gated) |
| stop_wr | input | 1 | Strobe: enter STOP (CPU clock and oscillator gated); wins over halt_wr |
| level_in | input | 2 | Current service level from the status word |
| mie | input | 1 | Master interrupt enable |
| ie | input | 32 | Per-source enable bits |
| irq_set | input | 32 | Per-source request raise pulses |
| nmi_set | input | 1 | Non-maskable request raise pulse |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| take_int | output | 1 | One-cycle strobe: vector to a service routine |
| take_nmi | output | 1 | Taken source is the non-maskable request |
| take_idx | output | 5 | Index of the taken maskable source |
| level_out | output | 2 | Updated service level |
| irq_pend | output | 32 | Pending maskable request flags |
| nmi_pend | output | 1 | Pending non-maskable flag |

## Verification
The stimulus puts the CPU to sleep and then raises requests under different mixes of `mie`, `ie` and `level_in`. One pattern is a disabled request, which must leave the CPU asleep. Others are a non-maskable request at a high level and at a low level, an enabled request with the master enable off, and an enabled request at level 1 and at level 0. Together these separate the wake decision from the vector decision. A burst of one non-maskable request and three maskable requests raised in the same cycle shows the service order. A sleep strobe given while a request is already pending shows that the wake is not lost. A scoreboard queue holds the expected wake and take events, in order, with source and level.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2
  } lpw_mode_e;

  localparam logic [1:0] LVL_IDLE = 2'd0;
  localparam logic [1:0] LVL_MASK = 2'd1;
  localparam logic [1:0] LVL_NMI  = 2'd2;
  localparam logic [1:0] LVL_DBG  = 2'd3;
endpackage

// File: rtl/lpw_prio_enc.sv
module lpw_prio_enc #(
  parameter int W = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     req,
  output logic [W-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
    any = |req;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any == (grant != '0))); // R10
endmodule

// File: rtl/lpw_req_bank.sv
module lpw_req_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] set,
  input  logic [BANK_W-1:0] clr,
  output logic [BANK_W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | set;
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set == '0 && clr == '0) |=> $stable(pend)); // R4
endmodule

// File: rtl/lpw_mode_ctl.sv
module lpw_mode_ctl
  import lpw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_wr,
  input  logic stop_wr,
  input  logic wake_src,
  output logic cpu_clk_en,
  output logic osc_en,
  output logic wake_pulse,
  output logic awake
);
  lpw_mode_e mode_q, mode_d;
  logic      wake_d;
  logic      asleep, sleep_req;

  assign asleep    = (mode_q != MODE_RUN);
  assign sleep_req = halt_wr | stop_wr;
  assign awake     = !asleep;

  always_comb begin
    mode_d = mode_q;
    wake_d = 1'b0;
    if (wake_src && (asleep || sleep_req)) begin
      mode_d = MODE_RUN;
      wake_d = 1'b1;
    end else if (stop_wr) begin
      mode_d = MODE_STOP;
    end else if (halt_wr) begin
      mode_d = MODE_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RUN;
      cpu_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      cpu_clk_en <= (mode_d == MODE_RUN);
      osc_en     <= (mode_d != MODE_STOP);
      wake_pulse <= wake_d;
    end
  end

  AST_OSC_NEEDS_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !cpu_clk_en); // R3
  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (cpu_clk_en && osc_en)); // R5
  AST_EARLY_WAKE: assert property (@(posedge clk) disable iff (rst)
    (awake && sleep_req && wake_src) |=> (wake_pulse && cpu_clk_en)); // R11
endmodule

// File: rtl/lpw_wake_arb.sv
module lpw_wake_arb
  import lpw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    halt_wr,
  input  logic                                    stop_wr,
  input  logic [1:0]                              level_in,
  input  logic                                    mie,
  input  logic [NUM_BANKS*BANK_W-1:0]             ie,
  input  logic [NUM_BANKS*BANK_W-1:0]             irq_set,
  input  logic                                    nmi_set,
  output logic                                    cpu_clk_en,
  output logic                                    osc_en,
  output logic                                    wake_pulse,
  output logic                                    take_int,
  output logic                                    take_nmi,
  output logic [$clog2(NUM_BANKS*BANK_W)-1:0]     take_idx,
  output logic [1:0]                              level_out,
  output logic [NUM_BANKS*BANK_W-1:0]             irq_pend,
  output logic                                    nmi_pend
);
  localparam int NSRC  = NUM_BANKS * BANK_W;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  en_req, grant, clr_mask;
  logic [IDX_W-1:0] win_idx;
  logic             any_req, wake_src, awake;
  logic             nmi_ok, mask_ok, take_nmi_now, take_mask_now;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lpw_req_bank #(.BANK_W(BANK_W)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .set  (irq_set[b*BANK_W +: BANK_W]),
      .clr  (clr_mask[b*BANK_W +: BANK_W]),
      .pend (irq_pend[b*BANK_W +: BANK_W])
    );
  end

  assign en_req   = irq_pend & ie;
  assign wake_src = nmi_pend | (|en_req);

  lpw_prio_enc #(.W(NSRC)) u_prio (
    .clk   (clk),
    .rst   (rst),
    .req   (en_req),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_req)
  );

  lpw_mode_ctl u_mode (
    .clk        (clk),
    .rst        (rst),
    .halt_wr    (halt_wr),
    .stop_wr    (stop_wr),
    .wake_src   (wake_src),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .wake_pulse (wake_pulse),
    .awake      (awake)
  );

  // Vector decision is separate from the wake decision.
  assign nmi_ok        = nmi_pend && (level_in == LVL_IDLE || level_in == LVL_MASK);
  assign mask_ok       = mie && (level_in == LVL_IDLE) && any_req;
  assign take_nmi_now  = awake && nmi_ok;
  assign take_mask_now = awake && !nmi_ok && mask_ok;
  assign clr_mask      = take_mask_now ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend  <= 1'b0;
      take_int  <= 1'b0;
      take_nmi  <= 1'b0;
      take_idx  <= '0;
      level_out <= LVL_IDLE;
    end else begin
      nmi_pend  <= (nmi_pend & ~take_nmi_now) | nmi_set;
      take_int  <= take_nmi_now | take_mask_now;
      take_nmi  <= take_nmi_now;
      take_idx  <= take_mask_now ? win_idx : '0;
      if (take_nmi_now)       level_out <= LVL_NMI;
      else if (take_mask_now) level_out <= LVL_MASK;
      else                    level_out <= level_in;
    end
  end

  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (take_int && take_nmi) |-> ($past(level_in) < LVL_NMI && level_out == LVL_NMI)); // R6
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    (take_int && !take_nmi) |-> ($past(mie) && $past(level_in) == LVL_IDLE)); // R9
  AST_TAKE_AWAKE: assert property (@(posedge clk) disable iff (rst)
    take_int |-> cpu_clk_en); // R9
endmodule

// File: tb/test_lpw_wake_arb.sv
module test_lpw_wake_arb;
  logic        clk = 1'b0;
  logic        rst;
  logic        halt_wr, stop_wr, mie, nmi_set;
  logic [1:0]  level_in;
  logic [31:0] ie, irq_set;
  logic        cpu_clk_en, osc_en, wake_pulse, take_int, take_nmi, nmi_pend;
  logic [4:0]  take_idx;
  logic [1:0]  level_out;
  logic [31:0] irq_pend;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // event: {kind(0 wake,1 take), nmi, idx[4:0], level[1:0]}
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  lpw_wake_arb i_lpw_wake_arb (
    .clk(clk), .rst(rst), .halt_wr(halt_wr), .stop_wr(stop_wr),
    .level_in(level_in), .mie(mie), .ie(ie), .irq_set(irq_set),
    .nmi_set(nmi_set), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .wake_pulse(wake_pulse), .take_int(take_int), .take_nmi(take_nmi),
    .take_idx(take_idx), .level_out(level_out), .irq_pend(irq_pend),
    .nmi_pend(nmi_pend)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_wake(string req);
    exp_q.push_back(9'h000);
    tag_q.push_back(req);
  endtask

  task automatic expect_take(logic nmi, logic [4:0] idx, logic [1:0] lvl, string req);
    exp_q.push_back({1'b1, nmi, idx, lvl});
    tag_q.push_back(req);
  endtask

  task automatic observe(logic [8:0] got);
    logic [8:0] want;
    string req;
    if (exp_q.size() == 0) begin
      check("unexpected event", {23'd0, got}, 32'h1ff);
    end else begin
      want = exp_q.pop_front();
      req  = tag_q.pop_front();
      check(req, {23'd0, got}, {23'd0, want});
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (wake_pulse) observe(9'h000);
      if (take_int)   observe({1'b1, take_nmi, take_idx, level_out});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep(logic deep);
    @(negedge clk);
    stop_wr = deep;
    halt_wr = !deep;
    @(negedge clk);
    stop_wr = 1'b0;
    halt_wr = 1'b0;
  endtask

  task automatic raise(logic [31:0] m, logic n);
    @(negedge clk);
    irq_set = m;
    nmi_set = n;
    @(negedge clk);
    irq_set = '0;
    nmi_set = 1'b0;
  endtask

  task automatic wrap_up();
    finished = 1;
    check("queue drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    rst = 1'b1; halt_wr = 0; stop_wr = 0; mie = 0; nmi_set = 0;
    level_in = 2'd0; ie = '0; irq_set = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 osc_en", osc_en, 1);
    check("R1 wake/take", {wake_pulse, take_int}, 0);
    check("R1 level_out", level_out, 0);
    check("R1 pending", {irq_pend, nmi_pend}, 0);

    // R2 halt gates only the CPU clock
    sleep(1'b0);
    check("R2 cpu_clk_en", cpu_clk_en, 0);
    check("R2 osc_en", osc_en, 1);

    // R4 disabled request stays pending and does not wake
    raise(32'h20, 1'b0);
    idle(4);
    check("R4 still asleep", cpu_clk_en, 0);
    check("R4 pending kept", irq_pend[5], 1);

    // R7 NMI at level 2 wakes without take; R5 regardless of mie/ie
    level_in = 2'd2;
    expect_wake("R7 wake");
    raise(32'h0, 1'b1);
    idle(4);
    check("R5 clocks back", {cpu_clk_en, osc_en}, 2'b11);
    check("R7 nmi stays pending", nmi_pend, 1);
    // R6 drain at level 0 while running
    expect_take(1'b1, 5'd0, 2'd2, "R6 take after level drop");
    level_in = 2'd0;
    idle(3);
    check("R6 nmi cleared", nmi_pend, 0);

    // R3 stop gates both, then R6 NMI at level 1
    sleep(1'b1);
    check("R3 cpu_clk_en", cpu_clk_en, 0);
    check("R3 osc_en", osc_en, 0);
    level_in = 2'd1;
    expect_wake("R5 nmi wake from stop");
    expect_take(1'b1, 5'd0, 2'd2, "R6 nmi take at level 1");
    raise(32'h0, 1'b1);
    idle(4);
    check("R6 level_out", level_out, 2'd1);
    check("R6 nmi cleared", nmi_pend, 0);

    // R8 enabled request with mie=0: wake, no take
    level_in = 2'd0; mie = 1'b0; ie = 32'h8;
    sleep(1'b0);
    expect_wake("R8 wake no vector");
    raise(32'h8, 1'b0);
    idle(4);
    check("R8 bit still pending", irq_pend[3], 1);

    // R11 sleep strobe with a pending enabled request
    expect_wake("R11 immediate wake");
    sleep(1'b0);
    check("R11 clock never gated", cpu_clk_en, 1);
    idle(3);

    // R9 mie=1 at level 1: no take; level 0: take
    mie = 1'b1; level_in = 2'd1;
    idle(3);
    check("R9 no take at level 1", irq_pend[3], 1);
    expect_take(1'b0, 5'd3, 2'd1, "R9 take bit 3");
    level_in = 2'd0;
    idle(3);
    check("R9 bit cleared", irq_pend[3], 0);

    // R9 wake without take at level 1, then take at level 0
    ie = 32'h1000; level_in = 2'd1;
    sleep(1'b0);
    expect_wake("R9 wake at level 1");
    raise(32'h1000, 1'b0);
    idle(4);
    expect_take(1'b0, 5'd12, 2'd1, "R9 take bit 12");
    level_in = 2'd0;
    idle(3);

    // R9 wake and take directly at level 0
    ie = 32'h10_0000;
    sleep(1'b1);
    expect_wake("R9 wake bit 20");
    expect_take(1'b0, 5'd20, 2'd1, "R9 take bit 20");
    raise(32'h10_0000, 1'b0);
    idle(4);
    check("R9 level_out", level_out, 2'd0);

    // R10 priority burst
    ie = ~32'h20;
    sleep(1'b0);
    expect_wake("R10 wake");
    expect_take(1'b1, 5'd0, 2'd2, "R10 nmi first");
    expect_take(1'b0, 5'd9, 2'd1, "R10 lowest index 9");
    expect_take(1'b0, 5'd17, 2'd1, "R10 index 17");
    expect_take(1'b0, 5'd30, 2'd1, "R10 index 30");
    raise(32'h4002_0200, 1'b1);
    idle(8);
    check("R10 all served", {irq_pend & ~32'h20, nmi_pend}, 0);
    check("R4 disabled bit never served", irq_pend[5], 1);
    wrap_up();
  end
endmodule